// File: doc/BRIEF.md
# Event Timer Comparator Channel

One channel of a high-precision event timer. The channel keeps its own configuration word, a comparator and a period register. It watches a free-running main counter that is shared with other channels and fires when the counter reaches the comparator value. The channel can run as a one-shot or a periodic timer. A channel can be held to a 32-bit counter width. It signals either by a single-cycle pulse (edge type) or by a latched status bit that holds the interrupt line until software clears it (level type). Its interrupt goes to a route index taken from the configuration. When legacy replacement is on, the first two channels instead use fixed indices.

Software reaches the channel through a word-wide register port with byte strobes. Word 0 is the configuration, word 1 is the comparator, word 2 is the period and word 3 is the status. The main counter, the global enable and the legacy-replacement flag come from the surrounding timer block. Resolving the route index into an interrupt controller input is left to the chip.

Top module: `etc_channel`

## Requirements
- R1: After reset the configuration reads as the route capability map in bits 63:32, bit 4 equal to the periodic capability and bit 5 equal to the 64-bit capability, with every other bit 0. The comparator reads all ones, the period reads 0, and the line and status are low.
- R2: A configuration write changes only bit 1 (1 = level, 0 = edge), bit 2 (channel enable), bit 3 (periodic, held 0 without periodic capability), bit 6 (set-value), bit 8 (force 32-bit) and bits 13:9 (route). All other bits keep their read-only or zero value.
- R3: Every register write changes only the byte lanes whose strobe bit is 1.
- R4: A configuration write that leaves bit 8 set clears bits 63:32 of both the comparator and the period on the next clock.
- R5: In one-shot edge mode the channel gives exactly one single-cycle line pulse when the counter equals the comparator, and the status stays 0.
- R6: In periodic mode with set-value on, a comparator write loads the comparator and the period with the same value and clears bit 6. Each later match adds the period to the comparator.
- R7: In 32-bit mode, comparator writes keep only the low 32 bits, matching uses only the counter's low 32 bits, and periodic addition wraps modulo 2^32.
- R8: In level mode a match sets the status bit (word 3, bit 0). The line stays high while the status bit is 1, and writing 1 to bit 0 of word 3 clears the status bit.
- R9: With the channel enable bit or the global enable at 0, a match produces neither a pulse nor a status bit.
- R10: With legacy replacement on, channel 0 reports route 0 and channel 1 reports route 8. Otherwise, and for all other channels, the route is configuration bits 13:9.
- R11: Writing 0 to status bit 0 leaves a set status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word select: 0 config, 1 comparator, 2 period, 3 status |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 64 | Write data |
| bus_wstrb | input | 8 | Byte-lane enables for a write |
| bus_rdata | output | 64 | Read data of the selected word, combinational |
| main_cnt | input | 64 | Shared main counter value |
| glb_en | input | 1 | Global timer enable |
| legacy_en | input | 1 | Legacy replacement routing |
| irq_route | output | 5 | Interrupt route index |
| irq_line | output | 1 | Interrupt line, pulse or held level |
| irq_status | output | 1 | Latched level-mode status |

## Verification
The main instance is channel 1 and has both the periodic and the 64-bit capability, plus a sparse route-capability map. With this build the bench can reach the fixed legacy index 8, exercise the set-value loading and cross a 32-bit wrap inside a 64-bit counter. A second instance shares the same register port and is built as channel 0 with neither capability. That instance shows the periodic bit held at zero, the reset word of a 32-bit-only channel and the legacy index 0.

// File: rtl/etc_pkg.sv
package etc_pkg;
  localparam int DW    = 64;
  localparam int BE_W  = DW / 8;
  localparam int LO_W  = 32;
  localparam int RT_W  = 5;

  // configuration bit positions (decoded by software and neighbours)
  localparam int B_LVL  = 1;
  localparam int B_EN   = 2;
  localparam int B_PER  = 3;
  localparam int B_PCAP = 4;
  localparam int B_SCAP = 5;
  localparam int B_SETV = 6;
  localparam int B_W32  = 8;
  localparam int B_RT   = 9;
  localparam int B_CAPS = 32;

  typedef enum logic [1:0] {
    ADR_CFG = 2'd0,
    ADR_CMP = 2'd1,
    ADR_PER = 2'd2,
    ADR_STS = 2'd3
  } adr_e;

  typedef struct packed {
    logic [RT_W-1:0] route;
    logic            w32;
    logic            setv;
    logic            per;
    logic            en;
    logic            lvl;
  } cfg_t;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [BE_W-1:0] strb);
    logic [DW-1:0] r;
    r = old_v;
    for (int b = 0; b < BE_W; b++) begin
      if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/etc_cfg_reg.sv
module etc_cfg_reg
  import etc_pkg::*;
#(
  parameter bit          PER_CAP   = 1'b1,
  parameter bit          SIZE_CAP  = 1'b1,
  parameter logic [31:0] ROUTE_CAP = 32'h0000_0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_cfg,
  input  logic [DW-1:0]   wdata,
  input  logic [BE_W-1:0] wstrb,
  input  logic            setv_clr,
  output cfg_t            cfg,
  output logic [DW-1:0]   cfg_word,
  output logic            trunc
);
  cfg_t          cfg_q, cfg_d;
  logic [DW-1:0] merged;
  logic          unused_bits;

  always_comb begin
    cfg_word                  = '0;
    cfg_word[B_LVL]           = cfg_q.lvl;
    cfg_word[B_EN]            = cfg_q.en;
    cfg_word[B_PER]           = cfg_q.per;
    cfg_word[B_PCAP]          = PER_CAP;
    cfg_word[B_SCAP]          = SIZE_CAP;
    cfg_word[B_SETV]          = cfg_q.setv;
    cfg_word[B_W32]           = cfg_q.w32;
    cfg_word[B_RT +: RT_W]    = cfg_q.route;
    cfg_word[B_CAPS +: 32]    = ROUTE_CAP;
  end

  assign merged      = lane_merge(cfg_word, wdata, wstrb);
  assign trunc       = wr_cfg & merged[B_W32];
  assign unused_bits = ^{merged[DW-1:B_RT+RT_W], merged[7], merged[5:4], merged[0]};

  always_comb begin
    cfg_d = cfg_q;
    if (wr_cfg) begin
      cfg_d.lvl   = merged[B_LVL];
      cfg_d.en    = merged[B_EN];
      cfg_d.per   = merged[B_PER] & PER_CAP;
      cfg_d.setv  = merged[B_SETV];
      cfg_d.w32   = merged[B_W32];
      cfg_d.route = merged[B_RT +: RT_W];
    end
    if (setv_clr) cfg_d.setv = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/etc_cmp_unit.sv
module etc_cmp_unit
  import etc_pkg::*;
#(
  parameter bit SIZE_CAP = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   main_cnt,
  input  logic            glb_en,
  input  logic            per_mode,
  input  logic            setv,
  input  logic            w32,
  input  logic            trunc,
  input  logic            wr_cmp,
  input  logic            wr_per,
  input  logic [DW-1:0]   wdata,
  input  logic [BE_W-1:0] wstrb,
  output logic [DW-1:0]   cmp_q,
  output logic [DW-1:0]   per_q,
  output logic            hit,
  output logic            setv_clr
);
  localparam logic [DW-1:0] LO_MASK = {{(DW-LO_W){1'b0}}, {LO_W{1'b1}}};

  logic          mode32, eq, armed_q, armed_d;
  logic [DW-1:0] msk, cmp_wv, per_wv, cmp_d, per_d, cmp_pre, sum;

  assign mode32 = w32 | !SIZE_CAP;
  assign msk    = mode32 ? LO_MASK : '1;
  assign cmp_wv = lane_merge(cmp_q, wdata, wstrb) & msk;
  assign per_wv = lane_merge(per_q, wdata, wstrb) & msk;

  assign eq  = mode32 ? (main_cnt[LO_W-1:0] == cmp_q[LO_W-1:0]) : (main_cnt == cmp_q);
  assign hit = eq & armed_q & glb_en;
  assign setv_clr = wr_cmp & per_mode & setv;

  always_comb begin
    if (mode32) sum = {{(DW-LO_W){1'b0}}, cmp_q[LO_W-1:0] + per_q[LO_W-1:0]};
    else        sum = cmp_q + per_q;
  end

  always_comb begin
    if (wr_cmp)              cmp_pre = cmp_wv;
    else if (hit && per_mode) cmp_pre = sum;
    else                     cmp_pre = cmp_q;
    cmp_d = trunc ? (cmp_pre & LO_MASK) : cmp_pre;

    per_d = per_q;
    if (wr_per)        per_d = per_wv;
    else if (setv_clr) per_d = cmp_wv;
    if (trunc)         per_d = per_d & LO_MASK;
  end

  // one firing per comparator value; a new value re-arms
  always_comb begin
    if (hit)               armed_d = per_mode;
    else if (wr_cmp || !eq) armed_d = 1'b1;
    else                   armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '1;
      per_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      cmp_q   <= cmp_d;
      per_q   <= per_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/etc_irq_gen.sv
module etc_irq_gen
  import etc_pkg::*;
#(
  parameter int CHAN_IDX = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic            ch_en,
  input  logic            lvl,
  input  logic [RT_W-1:0] route_cfg,
  input  logic            sts_clr,
  input  logic            legacy_en,
  output logic [RT_W-1:0] irq_route,
  output logic            irq_line,
  output logic            irq_status
);
  logic fire, sts_q, sts_d, pulse_q, pulse_d;

  assign fire = hit & ch_en;

  always_comb begin
    sts_d = sts_q;
    if (sts_clr)     sts_d = 1'b0;
    if (fire && lvl) sts_d = 1'b1;
    pulse_d = fire & !lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sts_q   <= sts_d;
      pulse_q <= pulse_d;
    end
  end

  assign irq_line   = sts_q | pulse_q;
  assign irq_status = sts_q;

  generate
    if (CHAN_IDX == 0) begin : g_leg0
      assign irq_route = legacy_en ? RT_W'(0) : route_cfg;
    end else if (CHAN_IDX == 1) begin : g_leg1
      assign irq_route = legacy_en ? RT_W'(8) : route_cfg;
    end else begin : g_plain
      logic unused_leg;
      assign unused_leg = legacy_en;
      assign irq_route  = route_cfg;
    end
  endgenerate
endmodule

// File: rtl/etc_channel.sv
module etc_channel
  import etc_pkg::*;
#(
  parameter int          CHAN_IDX  = 1,
  parameter bit          PER_CAP   = 1'b1,
  parameter bit          SIZE_CAP  = 1'b1,
  parameter logic [31:0] ROUTE_CAP = 32'h0000_0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [BE_W-1:0] bus_wstrb,
  output logic [DW-1:0]   bus_rdata,
  input  logic [DW-1:0]   main_cnt,
  input  logic            glb_en,
  input  logic            legacy_en,
  output logic [RT_W-1:0] irq_route,
  output logic            irq_line,
  output logic            irq_status
);
  cfg_t          cfg_f;
  logic [DW-1:0] cfg_word, cmp_val, per_val;
  logic          wr_cfg, wr_cmp, wr_per, sts_clr, trunc, hit, setv_clr;

  assign wr_cfg  = bus_wr && (adr_e'(bus_addr) == ADR_CFG);
  assign wr_cmp  = bus_wr && (adr_e'(bus_addr) == ADR_CMP);
  assign wr_per  = bus_wr && (adr_e'(bus_addr) == ADR_PER);
  assign sts_clr = bus_wr && (adr_e'(bus_addr) == ADR_STS) && bus_wstrb[0] && bus_wdata[0];

  etc_cfg_reg #(.PER_CAP(PER_CAP), .SIZE_CAP(SIZE_CAP), .ROUTE_CAP(ROUTE_CAP)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wdata(bus_wdata), .wstrb(bus_wstrb),
    .setv_clr(setv_clr), .cfg(cfg_f), .cfg_word(cfg_word), .trunc(trunc)
  );

  etc_cmp_unit #(.SIZE_CAP(SIZE_CAP)) cmp_i (
    .clk(clk), .rst_n(rst_n), .main_cnt(main_cnt), .glb_en(glb_en),
    .per_mode(cfg_f.per), .setv(cfg_f.setv), .w32(cfg_f.w32), .trunc(trunc),
    .wr_cmp(wr_cmp), .wr_per(wr_per), .wdata(bus_wdata), .wstrb(bus_wstrb),
    .cmp_q(cmp_val), .per_q(per_val), .hit(hit), .setv_clr(setv_clr)
  );

  etc_irq_gen #(.CHAN_IDX(CHAN_IDX)) irq_i (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ch_en(cfg_f.en), .lvl(cfg_f.lvl),
    .route_cfg(cfg_f.route), .sts_clr(sts_clr), .legacy_en(legacy_en),
    .irq_route(irq_route), .irq_line(irq_line), .irq_status(irq_status)
  );

  always_comb begin
    unique case (adr_e'(bus_addr))
      ADR_CFG: bus_rdata = cfg_word;
      ADR_CMP: bus_rdata = cmp_val;
      ADR_PER: bus_rdata = per_val;
      default: bus_rdata = {{(DW-1){1'b0}}, irq_status};
    endcase
  end
endmodule

// File: rtl/etc_channel_chk.sv
module etc_channel_chk #(
  parameter int CHAN_IDX = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       wd0,
  input logic       wd8,
  input logic       ws0,
  input logic       ws1,
  input logic       glb_en,
  input logic       legacy_en,
  input logic [4:0] irq_route,
  input logic       irq_line,
  input logic       irq_status,
  input logic       cfg_lvl,
  input logic       cfg_en,
  input logic       cfg_per,
  input logic       cfg_setv,
  input logic [31:0] cmp_hi,
  input logic [31:0] per_hi
);
  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr == 2'd3) && ws0 && wd0;

  // R4: 32-bit select clears upper halves
  p_trunc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && ws1 && wd8) |=> (cmp_hi == 32'h0 && per_hi == 32'h0));

  // R6: set-value clears after a comparator write
  p_setv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && cfg_per && cfg_setv) |=> !cfg_setv);

  // R8: status only latches in level mode
  p_status_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status) |-> $past(cfg_lvl));

  // R9: no line activity without both enables
  p_line_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_line) |-> $past(glb_en && cfg_en));

  // R11: status holds unless cleared by a 1
  p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status && !clr_wr) |=> irq_status);

  generate
    if (CHAN_IDX < 2) begin : g_leg
      localparam logic [4:0] LEG_IDX = (CHAN_IDX == 0) ? 5'd0 : 5'd8;
      // R10: fixed legacy index
      p_legacy_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_en |-> (irq_route == LEG_IDX));
    end
  endgenerate
endmodule

bind etc_channel etc_channel_chk #(.CHAN_IDX(CHAN_IDX)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd0(bus_wdata[0]), .wd8(bus_wdata[8]), .ws0(bus_wstrb[0]), .ws1(bus_wstrb[1]),
  .glb_en(glb_en), .legacy_en(legacy_en), .irq_route(irq_route),
  .irq_line(irq_line), .irq_status(irq_status),
  .cfg_lvl(cfg_f.lvl), .cfg_en(cfg_f.en), .cfg_per(cfg_f.per), .cfg_setv(cfg_f.setv),
  .cmp_hi(cmp_val[63:32]), .per_hi(per_val[63:32])
);

// File: tb/etc_channel_tb_top.sv
module etc_channel_tb_top;
  localparam logic [31:0] CAP1 = 32'h00C0_0300;
  localparam logic [31:0] CAP0 = 32'h0000_0005;

  logic        clk, rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr, glb_en, legacy_en, run, ld;
  logic [63:0] bus_wdata, rdata, rdata0, cnt, ld_val;
  logic [7:0]  bus_wstrb;
  logic [4:0]  route, route0;
  logic        line, status, line0, status0;

  int checks = 0, fails = 0;
  logic [63:0] exp_q[$];

  etc_channel #(.CHAN_IDX(1), .PER_CAP(1'b1), .SIZE_CAP(1'b1), .ROUTE_CAP(CAP1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_wstrb(bus_wstrb), .bus_rdata(rdata), .main_cnt(cnt), .glb_en(glb_en),
    .legacy_en(legacy_en), .irq_route(route), .irq_line(line), .irq_status(status));

  etc_channel #(.CHAN_IDX(0), .PER_CAP(1'b0), .SIZE_CAP(1'b0), .ROUTE_CAP(CAP0)) dut0_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_wstrb(bus_wstrb), .bus_rdata(rdata0), .main_cnt(cnt), .glb_en(glb_en),
    .legacy_en(legacy_en), .irq_route(route0), .irq_line(line0), .irq_status(status0));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (ld)       cnt <= ld_val;
    else if (run) cnt <= cnt + 64'd1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every edge pulse must match the next queued firing count
  always @(negedge clk) begin
    if (rst_n && line && !status) begin
      if (exp_q.size() == 0) check("R5 unexpected pulse at cnt-1", cnt - 64'd1, 64'hX);
      else check("R5/R6/R7 pulse position", cnt - 64'd1, exp_q.pop_front());
    end
  end

  task automatic expect_fire(input logic [63:0] v);
    exp_q.push_back(v);
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d, input logic [7:0] s);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
  endtask

  task automatic load_cnt(input logic [63:0] v);
    @(negedge clk);
    ld = 1'b1; ld_val = v;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic run_until(input logic [63:0] t);
    @(negedge clk);
    glb_en = 1'b1; run = 1'b1;
    while (cnt < t) @(negedge clk);
    glb_en = 1'b0; run = 1'b0;
  endtask

  task automatic finish_up;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all R actual=hung expected=done");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = '0; bus_wstrb = '0;
    glb_en = 1'b0; legacy_en = 1'b0; run = 1'b0; ld = 1'b1; ld_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; ld = 1'b0;

    // R1 reset state
    rd(2'd0); check("R1 cfg ch1", rdata, {CAP1, 32'h30});
    check("R1 cfg ch0", rdata0, {CAP0, 32'h0});
    rd(2'd1); check("R1 cmp", rdata, '1);
    rd(2'd2); check("R1 per", rdata, '0);
    check("R1 line/status", {63'd0, line | status}, '0);

    // R2 write mask, R4 truncation via bit 8
    wr(2'd0, '1, 8'hFF);
    rd(2'd0); check("R2 cfg all ones ch1", rdata, {CAP1, 32'h3F7E});
    check("R2 periodic held 0 ch0", rdata0, {CAP0, 32'h3F46});
    rd(2'd1); check("R4 cmp truncated", rdata, 64'h0000_0000_FFFF_FFFF);
    wr(2'd0, '0, 8'hFF);

    // R3 byte lanes
    wr(2'd0, 64'hFFFF, 8'h02);
    rd(2'd0); check("R3 cfg lane1 only", rdata, {CAP1, 32'h3F30});
    wr(2'd0, '0, 8'hFF);
    wr(2'd1, 64'h1111_2222_3333_4444, 8'h0F);
    rd(2'd1); check("R3 cmp low lanes", rdata, 64'h0000_0000_3333_4444);

    // R4 truncation of both registers
    wr(2'd2, 64'hABCD_0000_0000_0010, 8'hFF);
    wr(2'd1, 64'h5555_0000_0000_0100, 8'hFF);
    wr(2'd0, 64'h100, 8'hFF);
    rd(2'd1); check("R4 cmp", rdata, 64'h100);
    rd(2'd2); check("R4 per", rdata, 64'h10);

    // R5 one-shot edge
    wr(2'd0, 64'h4, 8'hFF);
    wr(2'd1, 64'h1010, 8'hFF);
    load_cnt(64'h1000);
    expect_fire(64'h1010);
    run_until(64'h1020);
    check("R5 pulses consumed", 64'(exp_q.size()), 64'd0);
    check("R5 status stays 0", {63'd0, status}, '0);

    // R6 periodic with set-value
    wr(2'd0, 64'h4C, 8'hFF);
    wr(2'd1, 64'h2010, 8'hFF);
    rd(2'd0); check("R6 set-value cleared", rdata, {CAP1, 32'h3C});
    rd(2'd2); check("R6 period loaded", rdata, 64'h2010);
    wr(2'd2, 64'h10, 8'hFF);
    load_cnt(64'h2000);
    expect_fire(64'h2010); expect_fire(64'h2020); expect_fire(64'h2030);
    run_until(64'h2038);
    check("R6 three periodic pulses", 64'(exp_q.size()), 64'd0);
    rd(2'd1); check("R6 comparator advanced", rdata, 64'h2040);

    // R7 32-bit periodic wrap
    wr(2'd0, 64'h10C, 8'hFF);
    wr(2'd2, 64'h10, 8'hFF);
    wr(2'd1, 64'h0000_0005_FFFF_FFF8, 8'hFF);
    rd(2'd1); check("R7 cmp low 32 only", rdata, 64'hFFFF_FFF8);
    load_cnt(64'h0000_0005_FFFF_FFF0);
    expect_fire(64'h0000_0005_FFFF_FFF8); expect_fire(64'h0000_0006_0000_0008);
    run_until(64'h0000_0006_0000_000C);
    check("R7 wrap pulses", 64'(exp_q.size()), 64'd0);
    rd(2'd1); check("R7 cmp wrapped", rdata, 64'h18);

    // R8 level, R11 write-0 ignored
    wr(2'd0, 64'h6, 8'hFF);
    wr(2'd1, 64'h3008, 8'hFF);
    load_cnt(64'h3000);
    run_until(64'h3010);
    rd(2'd3); check("R8 status set", rdata, 64'h1);
    check("R8 line held", {63'd0, line}, 64'h1);
    wr(2'd3, 64'h0, 8'hFF);
    rd(2'd3); check("R11 write 0 keeps status", rdata, 64'h1);
    wr(2'd3, 64'h1, 8'h00);
    rd(2'd3); check("R3 strobe-less clear ignored", rdata, 64'h1);
    wr(2'd3, 64'h1, 8'h01);
    rd(2'd3); check("R8 status cleared", rdata, 64'h0);
    check("R8 line released", {63'd0, line}, 64'h0);

    // R9 channel enable off, then global enable off
    wr(2'd0, 64'h2, 8'hFF);
    wr(2'd1, 64'h3020, 8'hFF);
    load_cnt(64'h3018);
    run_until(64'h3028);
    check("R9 chan disabled no status", {62'd0, line, status}, '0);
    wr(2'd0, 64'h6, 8'hFF);
    wr(2'd1, 64'h3038, 8'hFF);
    load_cnt(64'h3030);
    @(negedge clk); run = 1'b1;
    while (cnt < 64'h3040) @(negedge clk);
    run = 1'b0;
    check("R9 global off no status", {62'd0, line, status}, '0);

    // R10 routing
    wr(2'd0, 64'h1600, 8'hFF);
    @(negedge clk);
    check("R10 route field ch1", 64'(route), 64'd11);
    check("R10 route field ch0", 64'(route0), 64'd11);
    legacy_en = 1'b1;
    #1;
    check("R10 legacy ch1", 64'(route), 64'd8);
    check("R10 legacy ch0", 64'(route0), 64'd0);
    @(negedge clk); legacy_en = 1'b0; #1;
    check("R10 legacy off", 64'(route), 64'd11);

    finish_up();
  end
endmodule